// File: doc/BRIEF.md
# Banked-Window DMA Controller

This block is a byte-copy engine for a small 8-bit microcontroller whose external memory is reached through a 32 KB banked window at offsets 0x8000–0xFFFF. Software loads a source pointer, a destination pointer and a 16-bit byte count through byte-wide register writes. Each pointer is a 16-bit offset plus a 16-bit bank number. Writing the low byte of the count starts the copy. The CPU is then held by a stall output until the last byte has been written.

Offsets inside the window are turned into physical external addresses. Source accesses use the source bank and destination accesses use the destination bank. The destination bank is also the bank the CPU uses for its own window accesses, so it is brought out of the block. Offsets below the window, including the internal RAM at 0x0080–0x087F, pass through without banking.

Top module: `bnkdma_top`

## Requirements
- R1: While reset is held, and just after it is released, `cpu_stall`, `mem_rd` and `mem_wr` are low and every register is zero, so `cpu_win_bank` reads 0.
- R2: The register map is: 0x40/0x41 source offset low/high, 0x42/0x43 source bank low/high, 0x44/0x45 destination offset low/high, 0x46/0x47 destination bank low/high, 0x48 count high, 0x49 count low. A write to 0x49 whose resulting 16-bit count N is nonzero starts a copy. The count high byte must be written first. `cpu_stall` is high from the cycle after that write for exactly 2N cycles and drops in the cycle after the last write cycle.
- R3: Each byte takes one cycle with `mem_rd` high at the source address, then one cycle with `mem_wr` high at the destination address. `mem_wdata` equals the `mem_rdata` presented during that read cycle. The two strobes are never high together.
- R4: An offset of 0x8000 or more is driven with `mem_ext`=1 and `mem_addr` = bank*0x8000 + offset − 0x8000. Source accesses use the source bank and destination accesses use the destination bank.
- R5: An offset below 0x8000, including internal RAM 0x0080–0x087F, is driven with `mem_ext`=0 and `mem_addr` equal to the offset. The bank registers have no effect on it.
- R6: Both offsets advance by one per byte. An offset of 0xFFFF steps to 0x8000 and keeps its bank. An offset of 0x7FFF steps to 0x8000.
- R7: A count-low write that leaves the count at zero starts nothing, and `cpu_stall` stays low.
- R8: Register writes made while `cpu_stall` is high are ignored, including writes to 0x49.
- R9: After a copy, both offsets hold the address following the last byte and the count is zero. Writing only 0x49 then copies the next bytes from where the last copy stopped.
- R10: `cpu_win_bank` equals the destination bank register and does not change during a copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| mem_rd | output | 1 | Read strobe for the current cycle |
| mem_wr | output | 1 | Write strobe for the current cycle |
| mem_ext | output | 1 | 1: banked external access, 0: unbanked access |
| mem_addr | output | 31 | Physical or unbanked address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the read cycle |
| cpu_stall | output | 1 | Holds the CPU while a copy runs |
| cpu_win_bank | output | 16 | Bank used for the CPU's own window accesses |

## Verification
A register write is taken at the clock edge that follows its setup. A triggering write makes the first read strobe and the stall appear in the next cycle. After that, read and write cycles alternate, one clock each, and the stall drops in the cycle after the final write. The bench model turns every accepted trigger into a queue of expected per-cycle operations and pops one entry on each falling edge. Outputs are therefore compared half a cycle after the edge that produced them. A cycle with an empty queue must be idle with the stall low. Whether a register write counts as made during a copy is decided from the model's state in the cycle that ended at the write's edge.

// File: rtl/bnkdma_pkg.sv
package bnkdma_pkg;

    localparam int OFF_W   = 16;
    localparam int BANK_W  = 16;
    localparam int CNT_W   = 16;
    localparam int WIN_LOG = 15;
    localparam int PA_W    = BANK_W + WIN_LOG;
    localparam int RA_W    = 8;

    localparam logic [OFF_W-1:0] WIN_BASE = OFF_W'(1) << WIN_LOG;

    localparam logic [RA_W-1:0] RA_SOFF_LO = 8'h40;
    localparam logic [RA_W-1:0] RA_SOFF_HI = 8'h41;
    localparam logic [RA_W-1:0] RA_SBNK_LO = 8'h42;
    localparam logic [RA_W-1:0] RA_SBNK_HI = 8'h43;
    localparam logic [RA_W-1:0] RA_DOFF_LO = 8'h44;
    localparam logic [RA_W-1:0] RA_DOFF_HI = 8'h45;
    localparam logic [RA_W-1:0] RA_DBNK_LO = 8'h46;
    localparam logic [RA_W-1:0] RA_DBNK_HI = 8'h47;
    localparam logic [RA_W-1:0] RA_CNT_HI  = 8'h48;
    localparam logic [RA_W-1:0] RA_CNT_LO  = 8'h49;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } seq_st_t;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [OFF_W-1:0]  off;
    } ptr_t;

    typedef struct packed {
        logic            ext;
        logic [PA_W-1:0] addr;
    } phys_t;

    // Offset advance: wrap at the window top, bank never moves.
    function automatic ptr_t ptr_step(input ptr_t p);
        ptr_t r;
        r = p;
        if (p.off == '1)
            r.off = WIN_BASE;
        else
            r.off = p.off + OFF_W'(1);
        return r;
    endfunction

endpackage

// File: rtl/bnkdma_xlate.sv
module bnkdma_xlate
    import bnkdma_pkg::*;
(
    input  ptr_t  ptr,
    output phys_t phys
);
    logic in_win;

    assign in_win = ptr.off[OFF_W-1];

    always_comb begin
        phys.ext = in_win;
        if (in_win)
            phys.addr = {ptr.bank, ptr.off[WIN_LOG-1:0]};
        else
            phys.addr = {{(PA_W-OFF_W){1'b0}}, ptr.off};
    end
endmodule

// File: rtl/bnkdma_regs.sv
module bnkdma_regs
    import bnkdma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [RA_W-1:0]  wr_addr,
    input  logic [7:0]       wr_data,
    input  logic             busy,
    input  logic             step_src,
    input  logic             step_dst,
    output ptr_t             src,
    output ptr_t             dst,
    output logic [CNT_W-1:0] cnt,
    output logic             start
);
    logic             take;
    logic [CNT_W-1:0] cnt_new;

    assign take    = wr_en && !busy;
    assign cnt_new = {cnt[CNT_W-1:8], wr_data};
    assign start   = take && (wr_addr == RA_CNT_LO) && (cnt_new != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            src <= '0;
            dst <= '0;
            cnt <= '0;
        end else begin
            if (take) begin
                case (wr_addr)
                    RA_SOFF_LO: src.off[7:0]   <= wr_data;
                    RA_SOFF_HI: src.off[15:8]  <= wr_data;
                    RA_SBNK_LO: src.bank[7:0]  <= wr_data;
                    RA_SBNK_HI: src.bank[15:8] <= wr_data;
                    RA_DOFF_LO: dst.off[7:0]   <= wr_data;
                    RA_DOFF_HI: dst.off[15:8]  <= wr_data;
                    RA_DBNK_LO: dst.bank[7:0]  <= wr_data;
                    RA_DBNK_HI: dst.bank[15:8] <= wr_data;
                    RA_CNT_HI:  cnt[15:8]      <= wr_data;
                    RA_CNT_LO:  cnt[7:0]       <= wr_data;
                    default: ;
                endcase
            end
            if (step_src)
                src <= ptr_step(src);
            if (step_dst) begin
                dst <= ptr_step(dst);
                cnt <= cnt - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/bnkdma_seq.sv
module bnkdma_seq
    import bnkdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       last,
    input  logic [7:0] rd_data,
    output logic       rd_cyc,
    output logic       wr_cyc,
    output logic       busy,
    output logic [7:0] hold
);
    seq_st_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            hold <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) st <= ST_RD;
                ST_RD: begin
                    hold <= rd_data;
                    st   <= ST_WR;
                end
                ST_WR:   st <= last ? ST_IDLE : ST_RD;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign rd_cyc = (st == ST_RD);
    assign wr_cyc = (st == ST_WR);
    assign busy   = (st != ST_IDLE);
endmodule

// File: rtl/bnkdma_top.sv
module bnkdma_top
    import bnkdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              mem_ext,
    output logic [PA_W-1:0]   mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              cpu_stall,
    output logic [BANK_W-1:0] cpu_win_bank
);
    ptr_t             src, dst;
    phys_t            src_pa, dst_pa;
    logic [CNT_W-1:0] cnt;
    logic             start, busy, rd_cyc, wr_cyc;
    logic [7:0]       hold;

    bnkdma_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_we),
        .wr_addr  (reg_addr),
        .wr_data  (reg_wdata),
        .busy     (busy),
        .step_src (rd_cyc),
        .step_dst (wr_cyc),
        .src      (src),
        .dst      (dst),
        .cnt      (cnt),
        .start    (start)
    );

    bnkdma_xlate u_xsrc (.ptr(src), .phys(src_pa));
    bnkdma_xlate u_xdst (.ptr(dst), .phys(dst_pa));

    bnkdma_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .last    (cnt == CNT_W'(1)),
        .rd_data (mem_rdata),
        .rd_cyc  (rd_cyc),
        .wr_cyc  (wr_cyc),
        .busy    (busy),
        .hold    (hold)
    );

    assign mem_rd       = rd_cyc;
    assign mem_wr       = wr_cyc;
    assign mem_ext      = wr_cyc ? dst_pa.ext  : src_pa.ext;
    assign mem_addr     = wr_cyc ? dst_pa.addr : src_pa.addr;
    assign mem_wdata    = hold;
    assign cpu_stall    = busy;
    assign cpu_win_bank = dst.bank;
endmodule

// File: rtl/bnkdma_chk.sv
module bnkdma_chk
    import bnkdma_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [RA_W-1:0]   reg_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              mem_ext,
    input logic [PA_W-1:0]   mem_addr,
    input logic              cpu_stall,
    input logic [BANK_W-1:0] cpu_win_bank
);
    // R3
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R3
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> mem_wr);

    // R2
    stall_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_stall) |-> $past(reg_we && reg_addr == RA_CNT_LO));

    // R2
    wr_end_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> (mem_rd || !cpu_stall));

    // R2
    quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cpu_stall |-> (!mem_rd && !mem_wr));

    // R5
    low_direct_chk: assert property (@(posedge clk) disable iff (rst)
        ((mem_rd || mem_wr) && !mem_ext) |-> (mem_addr[PA_W-1:OFF_W-1] == '0));

    // R10
    bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_stall && $past(cpu_stall)) |-> $stable(cpu_win_bank));
endmodule

bind bnkdma_top bnkdma_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .mem_rd       (mem_rd),
    .mem_wr       (mem_wr),
    .mem_ext      (mem_ext),
    .mem_addr     (mem_addr),
    .cpu_stall    (cpu_stall),
    .cpu_win_bank (cpu_win_bank)
);

// File: tb/sim_bnkdma_top.sv
`timescale 1ns/1ps
module sim_bnkdma_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        mem_rd, mem_wr, mem_ext, cpu_stall;
    logic [30:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [15:0] cpu_win_bank;

    always #2 clk = ~clk;

    // Memory contents are a fixed function of the access
    function automatic logic [7:0] mem_fn(input logic ext, input logic [30:0] a);
        return a[7:0] ^ a[22:15] ^ a[30:23] ^ (ext ? 8'h5A : 8'h00);
    endfunction
    assign mem_rdata = mem_fn(mem_ext, mem_addr);

    bnkdma_top u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_ext(mem_ext), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .cpu_stall(cpu_stall), .cpu_win_bank(cpu_win_bank)
    );

    typedef struct packed {
        logic        rd;
        logic        wr;
        logic        ext;
        logic [30:0] addr;
        logic [7:0]  dat;
    } op_t;

    op_t    q[$];
    int     n_cmp = 0;
    int     n_bad = 0;
    bit     prev_busy = 0;
    bit     chk_on = 0;
    bit     done = 0;
    string  cur_req = "R1";

    longint m_soff = 0, m_sb = 0, m_doff = 0, m_db = 0, m_cnt = 0;

    function automatic void xl(input longint off, input longint bank,
                               output logic ext, output logic [30:0] a);
        if (off >= 32768) begin
            ext = 1'b1;
            a   = 31'(bank * 32768 + off - 32768);
        end else begin
            ext = 1'b0;
            a   = 31'(off);
        end
    endfunction

    function automatic longint nxt(input longint off);
        return (off == 65535) ? 32768 : off + 1;
    endfunction

    task automatic model_apply(input logic [7:0] a, input logic [7:0] d);
        op_t r, w;
        if (prev_busy) return;               // R8: ignored while stalled
        case (a)
            8'h40: m_soff = (m_soff & 'hFF00) | d;
            8'h41: m_soff = (m_soff & 'h00FF) | (longint'(d) << 8);
            8'h42: m_sb   = (m_sb & 'hFF00) | d;
            8'h43: m_sb   = (m_sb & 'h00FF) | (longint'(d) << 8);
            8'h44: m_doff = (m_doff & 'hFF00) | d;
            8'h45: m_doff = (m_doff & 'h00FF) | (longint'(d) << 8);
            8'h46: m_db   = (m_db & 'hFF00) | d;
            8'h47: m_db   = (m_db & 'h00FF) | (longint'(d) << 8);
            8'h48: m_cnt  = (m_cnt & 'h00FF) | (longint'(d) << 8);
            8'h49: begin
                m_cnt = (m_cnt & 'hFF00) | d;
                while (m_cnt != 0) begin
                    r = '0; w = '0;
                    r.rd = 1'b1;
                    xl(m_soff, m_sb, r.ext, r.addr);
                    w.wr = 1'b1;
                    xl(m_doff, m_db, w.ext, w.addr);
                    w.dat = mem_fn(r.ext, r.addr);
                    q.push_back(r);
                    q.push_back(w);
                    m_soff = nxt(m_soff);
                    m_doff = nxt(m_doff);
                    m_cnt  = m_cnt - 1;
                end
            end
            default: ;
        endcase
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1;
        model_apply(a, d);
        reg_we = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (q.size() != 0);
        @(negedge clk);
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (chk_on && !done) begin
            op_t e;
            bit  ok;
            n_cmp++;
            if (q.size() != 0) begin
                e = q.pop_front();
                prev_busy = 1;
                ok = cpu_stall && (mem_rd == e.rd) && (mem_wr == e.wr) &&
                     (mem_ext == e.ext) && (mem_addr == e.addr) &&
                     (!e.wr || mem_wdata == e.dat) && (cpu_win_bank == 16'(m_db));
                if (!ok) begin
                    n_bad++;
                    $display("FAIL %s: act stall=%0b rd=%0b wr=%0b ext=%0b addr=%h wd=%h bank=%h exp stall=1 rd=%0b wr=%0b ext=%0b addr=%h wd=%h bank=%h",
                        cur_req, cpu_stall, mem_rd, mem_wr, mem_ext, mem_addr, mem_wdata, cpu_win_bank,
                        e.rd, e.wr, e.ext, e.addr, e.dat, 16'(m_db));
                end
            end else begin
                prev_busy = 0;
                ok = !cpu_stall && !mem_rd && !mem_wr && (cpu_win_bank == 16'(m_db));
                if (!ok) begin
                    n_bad++;
                    $display("FAIL %s: act stall=%0b rd=%0b wr=%0b bank=%h exp idle stall=0 rd=0 wr=0 bank=%h",
                        cur_req, cpu_stall, mem_rd, mem_wr, cpu_win_bank, 16'(m_db));
                end
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: act running exp finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            n_cmp++;
            if (cpu_stall || mem_rd || mem_wr || cpu_win_bank != 16'h0) begin
                n_bad++;
                $display("FAIL R1: act stall=%0b rd=%0b wr=%0b bank=%h exp 0 0 0 0000",
                         cpu_stall, mem_rd, mem_wr, cpu_win_bank);
            end
        end
        rst = 1'b0;
        chk_on = 1;
        idle_cycles(3);

        // R2, R3: window source, unbanked destination, count above 255
        cur_req = "R2";
        wr(8'h40, 8'h00); wr(8'h41, 8'h90); wr(8'h42, 8'h03); wr(8'h43, 8'h00);
        wr(8'h44, 8'h00); wr(8'h45, 8'h02); wr(8'h48, 8'h01); wr(8'h49, 8'h02);
        wait_idle();
        cur_req = "R3";
        wr(8'h48, 8'h00); wr(8'h49, 8'h05);
        wait_idle();

        // R4: both sides banked, large bank numbers
        cur_req = "R4";
        wr(8'h40, 8'h00); wr(8'h41, 8'hC0); wr(8'h42, 8'h34); wr(8'h43, 8'h12);
        wr(8'h44, 8'h10); wr(8'h45, 8'h80); wr(8'h46, 8'hFF); wr(8'h47, 8'h00);
        wr(8'h48, 8'h00); wr(8'h49, 8'h03);
        wait_idle();

        // R5: internal RAM ends with banks loaded
        cur_req = "R5";
        wr(8'h40, 8'h80); wr(8'h41, 8'h00); wr(8'h42, 8'hAA); wr(8'h43, 8'h55);
        wr(8'h44, 8'h7D); wr(8'h45, 8'h08); wr(8'h46, 8'h11); wr(8'h47, 8'h22);
        wr(8'h49, 8'h04);
        wait_idle();

        // R6: wrap at window top, and entry from 0x7FFF
        cur_req = "R6";
        wr(8'h40, 8'hFE); wr(8'h41, 8'hFF); wr(8'h42, 8'h07); wr(8'h43, 8'h00);
        wr(8'h44, 8'hFD); wr(8'h45, 8'hFF); wr(8'h46, 8'h09); wr(8'h47, 8'h00);
        wr(8'h49, 8'h04);
        wait_idle();
        wr(8'h40, 8'hFE); wr(8'h41, 8'h7F); wr(8'h49, 8'h03);
        wait_idle();

        // R7: zero count
        cur_req = "R7";
        wr(8'h48, 8'h00); wr(8'h49, 8'h00);
        idle_cycles(4);

        // R8: writes during a copy
        cur_req = "R8";
        wr(8'h40, 8'h00); wr(8'h41, 8'hA0); wr(8'h44, 8'h00); wr(8'h45, 8'h01);
        wr(8'h49, 8'h06);
        wr(8'h46, 8'h77); wr(8'h40, 8'h55); wr(8'h49, 8'h09); wr(8'h45, 8'h03);
        wait_idle();

        // R9: continue from stored pointers
        cur_req = "R9";
        wr(8'h49, 8'h03);
        wait_idle();

        // R10: destination bank on the CPU window output
        cur_req = "R10";
        wr(8'h46, 8'hC3); wr(8'h47, 8'h5E);
        idle_cycles(3);
        wr(8'h44, 8'hF0); wr(8'h45, 8'hFF); wr(8'h49, 8'h20);
        wait_idle();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule